// File: doc/BRIEF.md
# SHA-1 Register Interface

This block is the processor-facing register front end for a SHA-1 compression engine. A bus master uses it to load a 512-bit message block as sixteen 32-bit words, to start a first-block or follow-on computation, to poll for completion, and to read the 160-bit result as five 32-bit words. The engine itself sits outside the block and is reached through a small set of core-side ports: a 512-bit block bus, start pulses for the first and the next block, and ready, valid and digest inputs.

Bus accesses take one cycle. Reads are combinational, so the data and the error flag are valid in the same cycle that chip select is high. Writes take effect at the clock edge that ends the access. The start bits in the control word do not hold their value. Each one turns into a single-cycle pulse to the engine, and the control word always reads back as zero. Stores to the message words are refused while the engine is busy. Any access that the address map does not allow raises the error flag for that one cycle.

Top module: `sha1_regif`

## Requirements
- R1: After reset all sixteen message words are zero, both start pulses are low, and the error flag is low.
- R2: A read of address 0x00 returns the first four identification characters and a read of 0x01 returns the next four. A read of 0x02 returns a four-character version. Each word holds its first character in bits 31:24.
- R3: A write to the control word at 0x08 with bit 0 set drives coreInit high for exactly the one cycle after the write. Bit 1 does the same for coreNext. A bit written as zero gives no pulse, and a read of 0x08 returns zero with no error.
- R4: A read of the status word at 0x09 returns the engine's ready flag in bit 0 and its digest-valid flag in bit 1. All other bits read as zero.
- R5: A write to address 0x10+i (i = 0..15) stores the data into message word i and raises no error. Word 0 drives coreBlock[511:480] and word 15 drives coreBlock[31:0]. A read of the same address returns the stored word.
- R6: A read of address 0x20+j (j = 0..4) returns digest word j. Word 0 is coreDigest[159:128] and word 4 is coreDigest[31:0].
- R7: Read data is valid in the same cycle as the access. When no read is in progress, rdData is zero.
- R8: A write to a read-only address (0x00-0x02, 0x09, 0x20-0x24) or to an unmapped address raises err in the access cycle only and changes no state. err is never high without cs.
- R9: A read from an unmapped address returns zero and raises err in that cycle.
- R10: While coreReady is low, a write to a message word is ignored and raises err. The stored word and coreBlock keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; an access takes place in every cycle it is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| err | output | 1 | Access error for the current cycle |
| coreInit | output | 1 | First-block start pulse to the engine |
| coreNext | output | 1 | Next-block start pulse to the engine |
| coreBlock | output | 512 | Message block, word 0 in the top bits |
| coreReady | input | 1 | Engine idle |
| coreValid | input | 1 | Engine digest valid |
| coreDigest | input | 160 | Engine result, word 0 in the top bits |

## Verification
The assertions assume that the engine does not lower coreReady without being asked: it goes busy only after an init or next pulse. They also assume that the bus inputs hold steady across the whole access cycle. The bench stands in for the engine with a model that goes busy for a fixed eight cycles after each pulse and then presents a digest taken from the first five message words, inverted on the next-block command. It changes bus inputs just after a rising edge and samples at the falling edge, so every access stays inside one settled cycle.

// File: rtl/sha1_regif_pkg.sv
package sha1_regif_pkg;
  localparam int WORD_W       = 32;
  localparam int ADDR_W       = 8;
  localparam int BLOCK_WORDS  = 16;
  localparam int DIGEST_WORDS = 5;
  localparam int BLOCK_W      = BLOCK_WORDS * WORD_W;
  localparam int DIGEST_W     = DIGEST_WORDS * WORD_W;
  localparam int IDX_W        = $clog2(BLOCK_WORDS);
  localparam int DIG_IDX_W    = $clog2(DIGEST_WORDS);

  localparam logic [ADDR_W-1:0] ADR_ID_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_ID_LO  = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_VER    = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h09;
  localparam logic [ADDR_W-1:0] ADR_BLOCK  = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_DIGEST = 8'h20;

  localparam int CTRL_INIT_BIT  = 0;
  localparam int CTRL_NEXT_BIT  = 1;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_VALID_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID_HI, SEL_ID_LO, SEL_VER, SEL_STATUS, SEL_BLOCK, SEL_DIGEST
  } readSel_t;

  typedef struct packed {
    logic             blockWr;
    logic             initCmd;
    logic             nextCmd;
    readSel_t         rdSel;
    logic [IDX_W-1:0] wordIdx;
  } strobe_t;
endpackage

// File: rtl/sha1_regif_ctrl.sv
module sha1_regif_ctrl
  import sha1_regif_pkg::*;
(
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              coreReady,
  output strobe_t           strobe,
  output logic              err
);
  logic isBlock;
  logic isDigest;

  always_comb begin
    isBlock  = (int'(addr) >= int'(ADR_BLOCK)) &&
               (int'(addr) <  int'(ADR_BLOCK) + BLOCK_WORDS);
    isDigest = (int'(addr) >= int'(ADR_DIGEST)) &&
               (int'(addr) <  int'(ADR_DIGEST) + DIGEST_WORDS);
  end

  always_comb begin
    strobe = '0;
    err    = 1'b0;
    if (isBlock)       strobe.wordIdx = IDX_W'(addr - ADR_BLOCK);
    else if (isDigest) strobe.wordIdx = IDX_W'(addr - ADR_DIGEST);
    if (cs && we) begin
      if (addr == ADR_CTRL) begin
        strobe.initCmd = wrData[CTRL_INIT_BIT];
        strobe.nextCmd = wrData[CTRL_NEXT_BIT];
      end else if (isBlock) begin
        if (coreReady) strobe.blockWr = 1'b1;
        else           err = 1'b1;
      end else begin
        err = 1'b1;
      end
    end else if (cs) begin
      if      (addr == ADR_ID_HI)  strobe.rdSel = SEL_ID_HI;
      else if (addr == ADR_ID_LO)  strobe.rdSel = SEL_ID_LO;
      else if (addr == ADR_VER)    strobe.rdSel = SEL_VER;
      else if (addr == ADR_STATUS) strobe.rdSel = SEL_STATUS;
      else if (isBlock)            strobe.rdSel = SEL_BLOCK;
      else if (isDigest)           strobe.rdSel = SEL_DIGEST;
      else if (addr != ADR_CTRL)   err = 1'b1;
    end
  end
endmodule

// File: rtl/sha1_regif_data.sv
module sha1_regif_data
  import sha1_regif_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_HI   = 32'h0,
  parameter logic [WORD_W-1:0] ID_LO   = 32'h0,
  parameter logic [WORD_W-1:0] VERSION = 32'h0
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                coreReady,
  input  logic                coreValid,
  input  logic [DIGEST_W-1:0] coreDigest,
  output logic [WORD_W-1:0]   rdData,
  output logic                coreInit,
  output logic                coreNext,
  output logic [BLOCK_W-1:0]  coreBlock
);
  logic [WORD_W-1:0] blockQ      [BLOCK_WORDS];
  logic [WORD_W-1:0] digestWords [DIGEST_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCK_WORDS; i++) blockQ[i] <= '0;
      coreInit <= 1'b0;
      coreNext <= 1'b0;
    end else begin
      if (strobe.blockWr) blockQ[strobe.wordIdx] <= wrData;
      coreInit <= strobe.initCmd;
      coreNext <= strobe.nextCmd;
    end
  end

  for (genvar i = 0; i < BLOCK_WORDS; i++) begin : gBlock
    assign coreBlock[(BLOCK_WORDS-1-i)*WORD_W +: WORD_W] = blockQ[i];
  end

  for (genvar j = 0; j < DIGEST_WORDS; j++) begin : gDigest
    assign digestWords[j] = coreDigest[(DIGEST_WORDS-1-j)*WORD_W +: WORD_W];
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_ID_HI:  rdData = ID_HI;
      SEL_ID_LO:  rdData = ID_LO;
      SEL_VER:    rdData = VERSION;
      SEL_STATUS: begin
        rdData[STAT_READY_BIT] = coreReady;
        rdData[STAT_VALID_BIT] = coreValid;
      end
      SEL_BLOCK:  rdData = blockQ[strobe.wordIdx];
      SEL_DIGEST: rdData = digestWords[strobe.wordIdx[DIG_IDX_W-1:0]];
      default:    rdData = '0;
    endcase
  end

  // R10: a busy engine leaves the message block untouched
  assert_block_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !coreReady |=> $stable(coreBlock));
endmodule

// File: rtl/sha1_regif.sv
module sha1_regif
  import sha1_regif_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_HI   = 32'h73686131,
  parameter logic [WORD_W-1:0] ID_LO   = 32'h5f726567,
  parameter logic [WORD_W-1:0] VERSION = 32'h312e3030
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cs,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic                err,
  output logic                coreInit,
  output logic                coreNext,
  output logic [BLOCK_W-1:0]  coreBlock,
  input  logic                coreReady,
  input  logic                coreValid,
  input  logic [DIGEST_W-1:0] coreDigest
);
  strobe_t strobe;

  sha1_regif_ctrl u_ctrl (
    .cs        (cs),
    .we        (we),
    .addr      (addr),
    .wrData    (wrData),
    .coreReady (coreReady),
    .strobe    (strobe),
    .err       (err)
  );

  sha1_regif_data #(
    .ID_HI   (ID_HI),
    .ID_LO   (ID_LO),
    .VERSION (VERSION)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .coreReady  (coreReady),
    .coreValid  (coreValid),
    .coreDigest (coreDigest),
    .rdData     (rdData),
    .coreInit   (coreInit),
    .coreNext   (coreNext),
    .coreBlock  (coreBlock)
  );

  assert_init_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    coreInit |-> $past(cs && we && addr == ADR_CTRL && wrData[CTRL_INIT_BIT]));

  assert_next_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    coreNext |-> $past(cs && we && addr == ADR_CTRL && wrData[CTRL_NEXT_BIT]));

  assert_block_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && addr == ADR_BLOCK && coreReady)
      |=> coreBlock[BLOCK_W-1 -: WORD_W] == $past(wrData));

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && !we) |-> rdData == '0);

  assert_err_needs_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> cs);
endmodule

// File: tb/sha1_regif_tb.sv
module sha1_regif_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cs = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic         err;
  logic         coreInit, coreNext;
  logic [511:0] coreBlock;
  logic         coreReady;
  logic         coreValid;
  logic [159:0] coreDigest;

  int checks = 0;
  int errors = 0;

  logic [31:0] qData[$];
  bit          qErr[$];
  bit          qRd[$];
  string       qTag[$];

  logic [31:0] words [16];

  always #4 clk = ~clk;

  sha1_regif u_dut (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wrData(wrData),
    .rdData(rdData), .err(err), .coreInit(coreInit), .coreNext(coreNext),
    .coreBlock(coreBlock), .coreReady(coreReady), .coreValid(coreValid),
    .coreDigest(coreDigest)
  );

  // engine stand-in: busy for 8 cycles after a start pulse
  int busyCnt;
  bit lastNext;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreReady <= 1'b1; coreValid <= 1'b0; coreDigest <= '0;
      busyCnt <= 0; lastNext <= 1'b0;
    end else if (busyCnt != 0) begin
      busyCnt <= busyCnt - 1;
      if (busyCnt == 1) begin
        coreReady  <= 1'b1;
        coreValid  <= 1'b1;
        coreDigest <= coreBlock[511:352] ^ {160{lastNext}};
      end
    end else if (coreInit || coreNext) begin
      coreReady <= 1'b0; coreValid <= 1'b0;
      busyCnt <= 8; lastNext <= coreNext;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per access cycle, compare at the falling edge
  always @(negedge clk) begin
    if (rstN && cs) begin
      if (qTag.size() == 0) begin
        check(1'b0, "scoreboard-empty", 32'h0, 32'h1);
      end else begin
        logic [31:0] d; bit e; bit r; string t;
        d = qData.pop_front(); e = qErr.pop_front();
        r = qRd.pop_front();   t = qTag.pop_front();
        check(err == e, {t, " err"}, {31'b0, err}, {31'b0, e});
        if (r) check(rdData == d, {t, " data"}, rdData, d);
      end
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d, bit expErr, string tag);
    @(posedge clk); #1;
    cs = 1; we = 1; addr = a; wrData = d;
    qData.push_back('0); qErr.push_back(expErr); qRd.push_back(1'b0); qTag.push_back(tag);
    @(posedge clk); #1;
    cs = 0; we = 0;
  endtask

  task automatic busRead(logic [7:0] a, logic [31:0] d, bit expErr, string tag);
    @(posedge clk); #1;
    cs = 1; we = 0; addr = a;
    qData.push_back(d); qErr.push_back(expErr); qRd.push_back(1'b1); qTag.push_back(tag);
    @(posedge clk); #1;
    cs = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(coreBlock == '0, "R1 block", coreBlock[31:0], 32'h0);
    check(!coreInit && !coreNext, "R1 pulses", {30'b0, coreInit, coreNext}, 32'h0);
    rstN = 1;
    @(negedge clk);
    check(err == 1'b0 && rdData == '0, "R1 R7 idle", rdData, 32'h0);
    busRead(8'h10, 32'h0, 0, "R1 word0");
    busRead(8'h1f, 32'h0, 0, "R1 word15");

    // R2: identification, first character in bits 31:24
    busRead(8'h00, 32'h73686131, 0, "R2 id hi");
    busRead(8'h01, 32'h5f726567, 0, "R2 id lo");
    busRead(8'h02, 32'h312e3030, 0, "R2 version");

    // R3 control reads zero; R4 status idle
    busRead(8'h08, 32'h0, 0, "R3 ctrl read");
    busRead(8'h09, 32'h1, 0, "R4 status idle");

    // R5 load message words and read back
    for (int i = 0; i < 16; i++) begin
      words[i] = 32'hA5000000 + i * 32'h01010101;
      busWrite(8'h10 + 8'(i), words[i], 0, "R5 write");
    end
    for (int i = 0; i < 16; i++) busRead(8'h10 + 8'(i), words[i], 0, "R5 readback");
    check(coreBlock[511:480] == words[0], "R5 msb word", coreBlock[511:480], words[0]);
    check(coreBlock[31:0] == words[15], "R5 lsb word", coreBlock[31:0], words[15]);

    // R3 zero control write gives no pulse
    busWrite(8'h08, 32'h0, 0, "R3 zero ctrl");
    @(negedge clk);
    check(!coreInit && !coreNext, "R3 no pulse", {30'b0, coreInit, coreNext}, 32'h0);

    // R3 init pulse lasts one cycle
    busWrite(8'h08, 32'h1, 0, "R3 init write");
    @(negedge clk);
    check(coreInit == 1'b1 && coreNext == 1'b0, "R3 init pulse", {30'b0, coreInit, coreNext}, 32'h2);
    @(negedge clk);
    check(coreInit == 1'b0, "R3 init clears", {31'b0, coreInit}, 32'h0);

    // R10 busy write ignored
    busWrite(8'h10, 32'hDEADBEEF, 1, "R10 busy write");
    busRead(8'h10, words[0], 0, "R10 word kept");
    busRead(8'h09, 32'h0, 0, "R4 status busy");
    wait (coreReady);
    busRead(8'h09, 32'h3, 0, "R4 status done");
    for (int j = 0; j < 5; j++) busRead(8'h20 + 8'(j), words[j], 0, "R6 digest init");

    // R3 next pulse, R6 digest word order
    busWrite(8'h08, 32'h2, 0, "R3 next write");
    @(negedge clk);
    check(coreNext == 1'b1 && coreInit == 1'b0, "R3 next pulse", {30'b0, coreInit, coreNext}, 32'h1);
    @(negedge clk);
    check(coreNext == 1'b0, "R3 next clears", {31'b0, coreNext}, 32'h0);
    wait (coreReady);
    for (int j = 0; j < 5; j++) busRead(8'h20 + 8'(j), ~words[j], 0, "R6 digest next");

    // R8 writes to read-only or unmapped addresses
    busWrite(8'h00, 32'h12345678, 1, "R8 write id");
    busRead(8'h00, 32'h73686131, 0, "R8 id kept");
    busWrite(8'h09, 32'hFFFFFFFF, 1, "R8 write status");
    busWrite(8'h22, 32'hFFFFFFFF, 1, "R8 write digest");
    busRead(8'h22, ~words[2], 0, "R8 digest kept");
    busWrite(8'h05, 32'h1, 1, "R8 write unmapped");
    busWrite(8'h30, 32'h1, 1, "R8 write above");
    @(negedge clk);
    check(!coreInit && !coreNext, "R8 no pulse", {30'b0, coreInit, coreNext}, 32'h0);

    // R9 unmapped reads
    busRead(8'h05, 32'h0, 1, "R9 read hole");
    busRead(8'h0a, 32'h0, 1, "R9 read after status");
    busRead(8'h25, 32'h0, 1, "R9 read after digest");
    busRead(8'hff, 32'h0, 1, "R9 read top");

    // R5 last word boundary
    busWrite(8'h1f, 32'h0BADF00D, 0, "R5 last word");
    @(negedge clk);
    check(coreBlock[31:0] == 32'h0BADF00D, "R5 last word bits", coreBlock[31:0], 32'h0BADF00D);

    repeat (2) @(posedge clk);
    if (qTag.size() != 0) check(1'b0, "scoreboard-leftover", qTag.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // R7: outside a read, read data stays zero and err stays low
  always @(negedge clk) begin
    if (rstN && !cs) begin
      if (rdData != '0 || err) check(1'b0, "R7 R8 idle outputs", rdData, 32'h0);
    end
  end
endmodule